// File: doc/BRIEF.md
# Chained Miscellaneous Interrupt Aggregator

This block gathers up to 32 single-bit interrupt sources from small peripherals and folds them into one request line for a parent interrupt controller. It holds a pending view and a per-source enable mask. Both are reached over a simple register bus that takes one cycle: a byte address, a write strobe, write data, and read data that is combinational from the current address. The parent line is high whenever any pending source is also enabled. Software reads pending and enable, ANDs them, and services the set bits in its own order.

A build-time parameter picks one of two variants. In the level variant the pending view is the live source lines. No state is kept for it, and a source is quietened only by clearing its enable bit. In the latched variant each pending bit is sticky. A source that is high sets its bit, and the bit stays set until software writes the pending register with that bit at 0. The write is a plain read-modify-write: a 1 leaves the bit alone and a 0 clears it.

Top module: `misc_irq_combiner`

## Requirements
- R1: While reset is held and right after it, reads of the pending register (byte offset 0) and the enable register (byte offset 4) return 0, and the parent line is low.
- R2: The enable register at byte offset 4 is a plain 32-bit read/write register. A read in the cycle after a write returns the written value, and the register keeps its value when it is not written.
- R3: The parent line is high exactly when the bitwise AND of the pending view and the enable register is nonzero.
- R4: Latched variant: a source that is high at a clock edge sets its pending bit, and the bit stays set after the source falls.
- R5: Latched variant: a write to offset 0 clears each pending bit written as 0 and leaves each bit written as 1 unchanged. A write of 1 never sets a bit.
- R6: Latched variant: when a source is high in the same cycle that its pending bit is written as 0, the bit stays set.
- R7: A source sets its pending bit even while its enable bit is 0, and the parent line rises as soon as that enable bit is written to 1.
- R8: Level variant: a read of offset 0 returns the current source levels, and writes to offset 0 have no effect on pending, enable or the parent line.
- R9: With all sources low, writing 0 to the enable register and then 0 to the pending register leaves both registers reading 0 and the parent line low.
- R10: Addresses other than 0 and 4 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Interrupt source lines, active high, bit i is source i |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | NUM_SRC | Write data |
| busRdData | output | NUM_SRC | Read data for busAddr, combinational |
| irqParent | output | 1 | Combined request to the parent controller |

## Verification
The bench drives both variants side by side with the same bus and source traffic. It goes after the corners where the latched logic can fail. A source that rises while the bit is written as 0 must stay pending; a design where the clear wins would drop an interrupt. A write of 1 must not set a bit; a design that stores the written word would invent a request. A pulse that arrives while masked must fire once it is unmasked; a design that gates the set with the enable would lose that pulse. Writes to unmapped addresses are also aimed at the enable register, where a loose decoder would corrupt the mask. Writes to the level variant's pending register are checked to leave the pending view and the parent line unchanged.

// File: rtl/misc_irq_pkg.sv
package misc_irq_pkg;

  // Decoded register access, passed from the control to the datapath
  typedef struct packed {
    logic selStatus;
    logic selEnable;
    logic wrStatus;
    logic wrEnable;
  } regStrobe_t;

endpackage

// File: rtl/misc_irq_ctrl.sv
module misc_irq_ctrl
  import misc_irq_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int STATUS_OFS = 0,
  parameter int ENABLE_OFS = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] StatusAddr = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] EnableAddr = ADDR_W'(ENABLE_OFS);

  // Exact address match; everything else is unmapped
  always_comb begin
    strobe.selStatus = (busAddr == StatusAddr);
    strobe.selEnable = (busAddr == EnableAddr);
    strobe.wrStatus  = busWrEn && strobe.selStatus;
    strobe.wrEnable  = busWrEn && strobe.selEnable;
  end

endmodule

// File: rtl/misc_irq_dp.sv
module misc_irq_dp
  import misc_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] wrData,
  input  regStrobe_t         strobe,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut
);

  logic [NUM_SRC-1:0] enableReg;
  logic [NUM_SRC-1:0] statusView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                enableReg <= '0;
    else if (strobe.wrEnable) enableReg <= wrData;
  end

  generate
    if (LATCHED) begin : g_latched
      logic [NUM_SRC-1:0] statusReg;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        // A high source outranks a clear in the same cycle
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                              statusReg[i] <= 1'b0;
          else if (srcIn[i])                      statusReg[i] <= 1'b1;
          else if (strobe.wrStatus && !wrData[i]) statusReg[i] <= 1'b0;
        end
      end
      assign statusView = statusReg;

      AST_SRC_SETS: assert property (@(posedge clk) disable iff (!rstN)
        (|srcIn) |=> ((statusReg & $past(srcIn)) == $past(srcIn)))
        else $error("source did not set pending"); // R6
      AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
        (|(~srcIn)) |=> ((statusReg & ~$past(statusReg) & ~$past(srcIn)) == '0))
        else $error("pending set without source"); // R5
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrStatus |=> ((statusReg & ~$past(srcIn) & ~$past(wrData)) == '0))
        else $error("pending not cleared"); // R5
    end else begin : g_level
      assign statusView = srcIn;
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (strobe.selStatus) rdData = statusView;
    if (strobe.selEnable) rdData = enableReg;
  end

  assign irqOut = |(statusView & enableReg);

  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnable |=> (enableReg == $past(wrData)))
    else $error("enable not loaded"); // R2
  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEnable |=> $stable(enableReg))
    else $error("enable changed without write"); // R10
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enableReg == '0) |-> !irqOut)
    else $error("request while all masked"); // R9

endmodule

// File: rtl/misc_irq_combiner.sv
module misc_irq_combiner
  import misc_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 3,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               irqParent
);

  regStrobe_t strobe;

  misc_irq_ctrl #(
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(0),
    .ENABLE_OFS(4)
  ) i_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  misc_irq_dp #(
    .NUM_SRC(NUM_SRC),
    .LATCHED(LATCHED)
  ) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .srcIn (srcIn),
    .wrData(busWrData),
    .strobe(strobe),
    .rdData(busRdData),
    .irqOut(irqParent)
  );

endmodule

// File: tb/test_misc_irq_combiner.sv
module test_misc_irq_combiner;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  srcIn = '0;
  logic [2:0]    busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [N-1:0]  busWrData = '0;
  logic [N-1:0]  rdLat, rdLvl;
  logic          irqLat, irqLvl;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  logic [N-1:0] mEn = '0;
  logic [N-1:0] mStat = '0;

  always #10 clk = ~clk;

  misc_irq_combiner #(.NUM_SRC(N), .ADDR_W(3), .LATCHED(1'b1)) i_misc_irq_combiner (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdLat), .irqParent(irqLat));

  misc_irq_combiner #(.NUM_SRC(N), .ADDR_W(3), .LATCHED(1'b0)) i_misc_irq_combiner_lvl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdLvl), .irqParent(irqLvl));

  function automatic logic [N-1:0] expRead(input logic lat, input logic [2:0] a,
                                           input logic [N-1:0] s);
    if (a == 3'd0) return lat ? mStat : s;
    if (a == 3'd4) return mEn;
    return '0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive one cycle, update the model at the edge, compare after it
  task automatic step(input string req, input logic [N-1:0] s, input logic [2:0] a,
                      input logic w, input logic [N-1:0] d);
    @(negedge clk);
    srcIn = s; busAddr = a; busWrEn = w; busWrData = d;
    @(posedge clk);
    if (w && a == 3'd4) mEn = d;
    mStat = ((w && a == 3'd0) ? (mStat & d) : mStat) | s;
    #1;
    chk(req, "latched read", rdLat, expRead(1'b1, a, s));
    chk(req, "level read", rdLvl, expRead(1'b0, a, s));
    chk(req, "latched irq", {31'd0, irqLat}, {31'd0, |(mStat & mEn)});
    chk(req, "level irq", {31'd0, irqLvl}, {31'd0, |(s & mEn)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    // R1: state during reset
    repeat (3) @(negedge clk);
    busAddr = 3'd0; #1;
    chk("R1", "status in reset", rdLat, '0);
    chk("R1", "irq in reset", {31'd0, irqLat | irqLvl}, '0);
    busAddr = 3'd4; #1;
    chk("R1", "enable in reset", rdLat | rdLvl, '0);
    rstN = 1'b1;
    step("R1", '0, 3'd0, 1'b0, '0);
    step("R1", '0, 3'd4, 1'b0, '0);

    // R2: enable read/write
    step("R2", '0, 3'd4, 1'b1, 32'hA5A5_0F0F);
    step("R2", '0, 3'd4, 1'b0, 32'hFFFF_FFFF);
    step("R2", '0, 3'd4, 1'b1, 32'h0000_0000);

    // R7 / R4: masked pulse is remembered and fires on unmask
    step("R4", 32'h0000_0008, 3'd0, 1'b0, '0);
    step("R4", '0, 3'd0, 1'b0, '0);
    step("R7", '0, 3'd4, 1'b1, 32'h0000_0008);
    step("R3", '0, 3'd0, 1'b0, '0);

    // R5: write 1 keeps, write 0 clears
    step("R5", '0, 3'd0, 1'b1, 32'hFFFF_FFFF);
    step("R5", '0, 3'd0, 1'b1, ~32'h0000_0008);
    step("R5", '0, 3'd0, 1'b0, '0);

    // R6: set wins over clear
    step("R6", 32'h0000_0020, 3'd0, 1'b1, 32'h0000_0000);
    step("R6", '0, 3'd0, 1'b0, '0);

    // R8: level view and ignored status writes
    step("R8", 32'h8000_0001, 3'd4, 1'b1, 32'h8000_0000);
    step("R8", 32'h8000_0001, 3'd0, 1'b1, 32'h0000_0000);
    step("R8", 32'h0000_0001, 3'd0, 1'b0, '0);

    // R10: unmapped addresses
    step("R10", '0, 3'd2, 1'b1, 32'hDEAD_BEEF);
    step("R10", '0, 3'd6, 1'b1, 32'h1234_5678);
    step("R10", '0, 3'd4, 1'b0, '0);

    // R3: random traffic
    for (int k = 0; k < 400; k++) begin
      logic [2:0] a;
      int pick;
      pick = $urandom_range(0, 4);
      a = (pick < 2) ? 3'd0 : (pick < 4) ? 3'd4 : 3'($urandom);
      step("R3", N'($urandom & $urandom & $urandom), a,
           1'($urandom_range(0, 2) == 0), N'($urandom | $urandom));
    end

    // R9: mask all, then clear all
    step("R9", '0, 3'd4, 1'b1, '0);
    step("R9", '0, 3'd0, 1'b1, '0);
    step("R9", '0, 3'd0, 1'b0, '0);
    step("R9", '0, 3'd4, 1'b0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule